// File: doc/BRIEF.md
# Nibble-Serial Instruction Decoder with Jump Prediction

This block sits between an instruction fetch unit and the execution back end. Fetch delivers whole cache lines as bundles, each tagged with a generation number and the line it holds, plus the line fetch intends to deliver next. The decoder walks the bytes of the current line starting at its program counter, up to four per cycle. Each byte adds one 4-bit nibble to one of four 32-bit instruction fields. A byte whose hold flag is clear ends the instruction, and the block then emits the instruction on a registered output with a valid/ready handshake.

When an emitted instruction is a conditional absolute jump, the block predicts it statically from the immediate flags. If the prediction moves the program counter off the line that fetch is streaming, the block asks fetch to resume at the right line. A jump that cannot be predicted freezes decoding until the back end restarts the front end. A back-end restart loads a new program counter and downstream generation, drops any half-built instruction and passes a restart with a fresh upstream generation on to fetch. Bundles that are stale, or that no longer hold the program counter's line, are popped without use.

Top module: `nd_decoder`

## Requirements
- R1: After reset, ins_valid, fr_valid and bnd_pop are 0, and both generation counters and the program counter are 0.
- R2: A byte is decoded as bits[3:0] nibble, bits[5:4] field select (0 opcode, 1 flags, 2 src1, 3 src2), bit 6 invert and bit 7 hold. The selected field is complemented when invert is 1, then shifted left by 4, and the nibble is placed in its low 4 bits.
- R3: In a cycle, lanes take consecutive bytes from the program counter's offset within the line. A byte is taken only while the bundle generation equals the upstream generation, bnd_line equals the program counter's line and the instruction output is free. Taking a byte adds 1 to the size and to the program counter. An instruction can span several cycles. At most one instruction completes per cycle, and no byte after the completing byte is taken in that cycle.
- R4: A byte with hold at 0 emits the instruction one cycle later with its size, its four fields, the downstream generation, and ins_lin_pc set to the address after its last byte. The partial state is then cleared.
- R5: Opcode 1 jumps if src2 is zero, and opcode 2 jumps if src2 is nonzero. Flags bit 0 marks the target (src1) as known, and flags bit 1 marks the condition as known. With a known target and a known condition, the block redirects when the jump is taken. With a known target and an unknown condition, it redirects only when the target is below ins_lin_pc. On a redirect, ins_pred_pc and the program counter take the target. Otherwise ins_pred_pc equals ins_lin_pc.
- R6: If the target is unknown and the condition is unknown or taken, the jump is unpredictable. ins_pred_ok is then 0 and the size is set to 64. While the size is 64 or more, no byte is taken and no bundle is popped.
- R7: A back-end restart overrides all decoding in its cycle. It loads the program counter and the downstream generation, clears the partial instruction and increments the upstream generation. One cycle later, fr_valid pulses with the new upstream generation, the new program counter's line and rs_from_line.
- R8: If a bundle of the current generation has both bnd_line and bnd_next_line different from the line of the updated program counter, the upstream generation is incremented. A fetch restart then carries that line as the new line and bnd_line as the previous line.
- R9: While not restarting or stalled, bnd_pop is 1 in the same cycle when the bundle's generation is stale or its line differs from the updated program counter's line. Otherwise bnd_pop is 0.
- R10: While ins_valid is 1 and ins_ready is 0, the output is held and no byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rs_valid | input | 1 | Back-end restart request |
| rs_gen | input | GEN_W | New downstream generation |
| rs_pc | input | PC_W | New program counter |
| rs_from_line | input | PC_W-OFF_W | Line of the instruction that caused the restart |
| bnd_valid | input | 1 | A bundle is offered |
| bnd_gen | input | GEN_W | Generation of the offered bundle |
| bnd_line | input | PC_W-OFF_W | Line held by the bundle |
| bnd_next_line | input | PC_W-OFF_W | Line fetch will send next |
| bnd_data | input | 8<<OFF_W | Line bytes, byte 0 in bits [7:0] |
| bnd_pop | output | 1 | Drop the offered bundle this cycle |
| fr_valid | output | 1 | Restart request to fetch |
| fr_gen | output | GEN_W | New upstream generation for fetch |
| fr_new_line | output | PC_W-OFF_W | Line where fetch should resume |
| fr_prev_line | output | PC_W-OFF_W | Line whose successor was wrong |
| ins_valid | output | 1 | Instruction available |
| ins_ready | input | 1 | Consumer takes the instruction |
| ins_size | output | SIZE_W | Instruction length in bytes |
| ins_op | output | FIELD_W | Opcode field |
| ins_flags | output | FIELD_W | Flags/destination field |
| ins_src1 | output | FIELD_W | Source 1 field |
| ins_src2 | output | FIELD_W | Source 2 field |
| ins_gen | output | GEN_W | Downstream generation |
| ins_lin_pc | output | PC_W | Address after the instruction |
| ins_pred_pc | output | PC_W | Predicted next address |
| ins_pred_ok | output | 1 | Prediction is valid |

## Verification
The bench uses the default parameters: 16-byte lines, four lanes, 32-bit program counter and fields, an 8-bit generation and a 64-byte length limit. With only four lanes, a five-byte instruction already spans two cycles. Targets of two nibbles are enough to jump both below and above the current address. So redirects that leave the streamed line and trigger fetch restarts, non-redirects, and unpredictable stalls can all be reached with short byte strings. A 16-byte line also leaves room for several back-to-back instructions and a backpressure stall inside one bundle.

// File: rtl/nd_pkg.sv
package nd_pkg;
  localparam int NFLD   = 4;
  localparam int F_OP   = 0;
  localparam int F_FLG  = 1;
  localparam int F_SRC1 = 2;
  localparam int F_SRC2 = 3;

  localparam int OP_JZ  = 1;
  localparam int OP_JNZ = 2;

  localparam int FLG_TGT_KNOWN  = 0;
  localparam int FLG_COND_KNOWN = 1;

  typedef struct packed {
    logic       hold;
    logic       inv;
    logic [1:0] fsel;
    logic [3:0] nib;
  } dbyte_t;
endpackage

// File: rtl/nd_lane.sv
module nd_lane
  import nd_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int OFF_W   = 4,
  parameter int FIELD_W = 32,
  parameter int SIZE_W  = 7,
  localparam int LINE_W = PC_W - OFF_W,
  localparam int DATA_W = 8 << OFF_W
) (
  input  logic                           en_i,
  input  logic                           gen_ok_i,
  input  logic [LINE_W-1:0]              line_i,
  input  logic [DATA_W-1:0]              data_i,
  input  logic [PC_W-1:0]                pc_i,
  input  logic [SIZE_W-1:0]              size_i,
  input  logic [NFLD-1:0][FIELD_W-1:0]   fld_i,
  output logic                           en_o,
  output logic                           done_o,
  output logic [PC_W-1:0]                pc_o,
  output logic [SIZE_W-1:0]              size_o,
  output logic [NFLD-1:0][FIELD_W-1:0]   fld_o
);
  logic               hit;
  dbyte_t             b;
  logic [FIELD_W-1:0] sel;

  always_comb begin
    hit    = en_i && gen_ok_i && (pc_i[PC_W-1:OFF_W] == line_i);
    b      = data_i[8*pc_i[OFF_W-1:0] +: 8];
    sel    = fld_i[b.fsel];
    if (b.inv) sel = ~sel;
    fld_o  = fld_i;
    pc_o   = pc_i;
    size_o = size_i;
    if (hit) begin
      fld_o[b.fsel] = {sel[FIELD_W-5:0], b.nib};
      pc_o          = pc_i + 1'b1;
      size_o        = size_i + 1'b1;
    end
    done_o = hit && !b.hold;
    en_o   = hit && b.hold;
  end
endmodule

// File: rtl/nd_predict.sv
module nd_predict
  import nd_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int FIELD_W = 32
) (
  input  logic [FIELD_W-1:0] op_i,
  input  logic [1:0]         flg_i,
  input  logic [PC_W-1:0]    src1_i,
  input  logic [FIELD_W-1:0] src2_i,
  input  logic [PC_W-1:0]    lin_pc_i,
  output logic               redirect_o,
  output logic               unpred_o,
  output logic [PC_W-1:0]    target_o
);
  logic is_jz, is_jnz, is_jmp, tgt_known, cond_known, taken;

  always_comb begin
    is_jz      = op_i == FIELD_W'(OP_JZ);
    is_jnz     = op_i == FIELD_W'(OP_JNZ);
    is_jmp     = is_jz || is_jnz;
    tgt_known  = flg_i[FLG_TGT_KNOWN];
    cond_known = flg_i[FLG_COND_KNOWN];
    taken      = is_jz ? (src2_i == '0) : (src2_i != '0);
    target_o   = src1_i;
    redirect_o = is_jmp && tgt_known &&
                 (cond_known ? taken : (src1_i < lin_pc_i));
    unpred_o   = is_jmp && !tgt_known && (!cond_known || taken);
  end
endmodule

// File: rtl/nd_decoder.sv
module nd_decoder
  import nd_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int OFF_W   = 4,
  parameter int FIELD_W = 32,
  parameter int GEN_W   = 8,
  parameter int LANES   = 4,
  parameter int MAX_LEN = 64,
  localparam int LINE_W = PC_W - OFF_W,
  localparam int DATA_W = 8 << OFF_W,
  localparam int SIZE_W = $clog2(MAX_LEN + LANES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rs_valid,
  input  logic [GEN_W-1:0]   rs_gen,
  input  logic [PC_W-1:0]    rs_pc,
  input  logic [LINE_W-1:0]  rs_from_line,
  input  logic               bnd_valid,
  input  logic [GEN_W-1:0]   bnd_gen,
  input  logic [LINE_W-1:0]  bnd_line,
  input  logic [LINE_W-1:0]  bnd_next_line,
  input  logic [DATA_W-1:0]  bnd_data,
  output logic               bnd_pop,
  output logic               fr_valid,
  output logic [GEN_W-1:0]   fr_gen,
  output logic [LINE_W-1:0]  fr_new_line,
  output logic [LINE_W-1:0]  fr_prev_line,
  output logic               ins_valid,
  input  logic               ins_ready,
  output logic [SIZE_W-1:0]  ins_size,
  output logic [FIELD_W-1:0] ins_op,
  output logic [FIELD_W-1:0] ins_flags,
  output logic [FIELD_W-1:0] ins_src1,
  output logic [FIELD_W-1:0] ins_src2,
  output logic [GEN_W-1:0]   ins_gen,
  output logic [PC_W-1:0]    ins_lin_pc,
  output logic [PC_W-1:0]    ins_pred_pc,
  output logic               ins_pred_ok
);
  logic [PC_W-1:0]                  pc_q;
  logic [SIZE_W-1:0]                size_q;
  logic [NFLD-1:0][FIELD_W-1:0]     fld_q;
  logic [GEN_W-1:0]                 gup_q, gdn_q;

  logic [LANES:0]                   en;
  logic [LANES-1:0]                 done;
  logic [PC_W-1:0]                  pc_c   [LANES+1];
  logic [SIZE_W-1:0]                size_c [LANES+1];
  logic [NFLD-1:0][FIELD_W-1:0]     fld_c  [LANES+1];

  logic stalled, out_free, gen_match, go, done_any, redirect, unpred, lost;
  logic [PC_W-1:0]   target, pc_next;
  logic [LINE_W-1:0] line_next;

  always_comb begin
    stalled   = size_q >= SIZE_W'(MAX_LEN);
    out_free  = !ins_valid || ins_ready;
    gen_match = bnd_gen == gup_q;
    go        = !rs_valid && !stalled && bnd_valid;
    en[0]     = go && out_free;
    pc_c[0]   = pc_q;
    size_c[0] = size_q;
    fld_c[0]  = fld_q;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    nd_lane #(
      .PC_W(PC_W), .OFF_W(OFF_W), .FIELD_W(FIELD_W), .SIZE_W(SIZE_W)
    ) lane_i (
      .en_i    (en[i]),
      .gen_ok_i(gen_match),
      .line_i  (bnd_line),
      .data_i  (bnd_data),
      .pc_i    (pc_c[i]),
      .size_i  (size_c[i]),
      .fld_i   (fld_c[i]),
      .en_o    (en[i+1]),
      .done_o  (done[i]),
      .pc_o    (pc_c[i+1]),
      .size_o  (size_c[i+1]),
      .fld_o   (fld_c[i+1])
    );
  end

  nd_predict #(.PC_W(PC_W), .FIELD_W(FIELD_W)) pred_i (
    .op_i      (fld_c[LANES][F_OP]),
    .flg_i     (fld_c[LANES][F_FLG][1:0]),
    .src1_i    (fld_c[LANES][F_SRC1][PC_W-1:0]),
    .src2_i    (fld_c[LANES][F_SRC2]),
    .lin_pc_i  (pc_c[LANES]),
    .redirect_o(redirect),
    .unpred_o  (unpred),
    .target_o  (target)
  );

  always_comb begin
    done_any  = |done;
    pc_next   = (done_any && redirect) ? target : pc_c[LANES];
    line_next = pc_next[PC_W-1:OFF_W];
    lost      = go && gen_match && (bnd_line != line_next) &&
                (bnd_next_line != line_next);
    bnd_pop   = go && (!gen_match || (bnd_line != line_next));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q         <= '0;
      size_q       <= '0;
      fld_q        <= '0;
      gup_q        <= '0;
      gdn_q        <= '0;
      fr_valid     <= 1'b0;
      fr_gen       <= '0;
      fr_new_line  <= '0;
      fr_prev_line <= '0;
      ins_valid    <= 1'b0;
      ins_size     <= '0;
      ins_op       <= '0;
      ins_flags    <= '0;
      ins_src1     <= '0;
      ins_src2     <= '0;
      ins_gen      <= '0;
      ins_lin_pc   <= '0;
      ins_pred_pc  <= '0;
      ins_pred_ok  <= 1'b0;
    end else begin
      fr_valid <= 1'b0;
      if (ins_valid && ins_ready) ins_valid <= 1'b0;
      if (rs_valid) begin
        gdn_q        <= rs_gen;
        pc_q         <= rs_pc;
        size_q       <= '0;
        fld_q        <= '0;
        gup_q        <= gup_q + 1'b1;
        fr_valid     <= 1'b1;
        fr_gen       <= gup_q + 1'b1;
        fr_new_line  <= rs_pc[PC_W-1:OFF_W];
        fr_prev_line <= rs_from_line;
      end else if (go) begin
        pc_q <= pc_next;
        if (done_any) begin
          ins_valid   <= 1'b1;
          ins_size    <= size_c[LANES];
          ins_op      <= fld_c[LANES][F_OP];
          ins_flags   <= fld_c[LANES][F_FLG];
          ins_src1    <= fld_c[LANES][F_SRC1];
          ins_src2    <= fld_c[LANES][F_SRC2];
          ins_gen     <= gdn_q;
          ins_lin_pc  <= pc_c[LANES];
          ins_pred_pc <= pc_next;
          ins_pred_ok <= !unpred;
          size_q      <= unpred ? SIZE_W'(MAX_LEN) : '0;
          fld_q       <= '0;
        end else begin
          size_q <= size_c[LANES];
          fld_q  <= fld_c[LANES];
        end
        if (lost) begin
          gup_q        <= gup_q + 1'b1;
          fr_valid     <= 1'b1;
          fr_gen       <= gup_q + 1'b1;
          fr_new_line  <= line_next;
          fr_prev_line <= bnd_line;
        end
      end
    end
  end

  AST_ONE_DONE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done)); // R3

  AST_RESTART_FWD: assert property (@(posedge clk) disable iff (rst)
    rs_valid |=> fr_valid && (fr_new_line == $past(rs_pc[PC_W-1:OFF_W]))
                 && (fr_prev_line == $past(rs_from_line))); // R7

  AST_STALL_NO_POP: assert property (@(posedge clk) disable iff (rst)
    (stalled && !rs_valid) |-> !bnd_pop && !done_any); // R6

  AST_STALL_PC: assert property (@(posedge clk) disable iff (rst)
    (stalled && !rs_valid) |=> $stable(pc_q)); // R6

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && !ins_ready && !rs_valid) |=> ins_valid && $stable(ins_op)
                                   && $stable(ins_lin_pc)); // R10
endmodule

// File: tb/nd_decoder_tb.sv
`timescale 1ns/1ps
module nd_decoder_tb_top;
  logic         clk = 1'b0;
  logic         rst;
  logic         rs_valid;
  logic [7:0]   rs_gen;
  logic [31:0]  rs_pc;
  logic [27:0]  rs_from_line;
  logic         bnd_valid;
  logic [7:0]   bnd_gen;
  logic [27:0]  bnd_line, bnd_next_line;
  logic [127:0] bnd_data;
  logic         bnd_pop, fr_valid, ins_valid, ins_ready, ins_pred_ok;
  logic [7:0]   fr_gen, ins_gen;
  logic [27:0]  fr_new_line, fr_prev_line;
  logic [6:0]   ins_size;
  logic [31:0]  ins_op, ins_flags, ins_src1, ins_src2, ins_lin_pc, ins_pred_pc;

  int   n_run = 0, n_fail = 0;
  logic [7:0]  gup = 8'd0;
  logic [31:0] mf [4];
  int          msz;
  logic        pop_s;

  always #10 clk = ~clk;

  nd_decoder dut_i (
    .clk, .rst, .rs_valid, .rs_gen, .rs_pc, .rs_from_line,
    .bnd_valid, .bnd_gen, .bnd_line, .bnd_next_line, .bnd_data, .bnd_pop,
    .fr_valid, .fr_gen, .fr_new_line, .fr_prev_line,
    .ins_valid, .ins_ready, .ins_size, .ins_op, .ins_flags, .ins_src1,
    .ins_src2, .ins_gen, .ins_lin_pc, .ins_pred_pc, .ins_pred_ok
  );

  localparam logic [31:0] VEC [4] = '{32'h00000005, 32'h00038281,
                                      32'h0007D09A, 32'h09F3B2A1};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_rs(input logic [31:0] p, input logic [7:0] g, input logic [27:0] from);
    rs_valid = 1'b1; rs_pc = p; rs_gen = g; rs_from_line = from;
    step();
    rs_valid = 1'b0;
    gup = gup + 8'd1;
  endtask

  task automatic put(input int off, input logic [7:0] v);
    bnd_data[off*8 +: 8] = v;
  endtask

  task automatic offer(input logic [27:0] line);
    bnd_valid = 1'b1; bnd_gen = gup; bnd_line = line; bnd_next_line = line + 28'd1;
  endtask

  // bench model of the byte rule (R2)
  task automatic model(input logic [31:0] w);
    for (int i = 0; i < 4; i++) mf[i] = 32'd0;
    msz = 0;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b;
      b = w[i*8 +: 8];
      if (b[6]) mf[b[5:4]] = ~mf[b[5:4]];
      mf[b[5:4]] = {mf[b[5:4]][27:0], b[3:0]};
      msz++;
      if (!b[7]) break;
    end
  endtask

  task automatic run_jump(input logic [31:0] base, input logic [7:0] op,
                          input logic [3:0] fl, input logic [3:0] thi,
                          input logic [3:0] tlo, input logic [3:0] s2);
    do_rs(base, 8'h70, base[31:4]);
    bnd_data = '0;
    put(0, {4'h9, fl}); put(1, {4'hA, thi}); put(2, {4'hA, tlo});
    put(3, {4'hB, s2}); put(4, op);
    offer(base[31:4]);
    step();
    chk("R3 jump part one not emitted", ins_valid, 0);
    #1 pop_s = bnd_pop;
    step();
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; rs_valid = 1'b0; rs_gen = '0; rs_pc = '0; rs_from_line = '0;
    bnd_valid = 1'b0; bnd_gen = '0; bnd_line = '0; bnd_next_line = '0;
    bnd_data = '0; ins_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 ins_valid", ins_valid, 0);
    chk("R1 fr_valid", fr_valid, 0);
    chk("R1 bnd_pop", bnd_pop, 0);
    @(negedge clk);

    // R7: restart with a bundle present; restart wins
    bnd_data = '0; put(0, 8'h05);
    bnd_valid = 1'b1; bnd_gen = 8'd0; bnd_line = 28'h20; bnd_next_line = 28'h21;
    rs_valid = 1'b1; rs_pc = 32'h200; rs_gen = 8'h55; rs_from_line = 28'h4A;
    #1 chk("R7 no pop during restart", bnd_pop, 0);
    step(); rs_valid = 1'b0; gup = gup + 8'd1;
    chk("R7 fr_valid", fr_valid, 1);
    chk("R7 fr_gen", fr_gen, 1);
    chk("R7 fr_new_line", fr_new_line, 28'h20);
    chk("R7 fr_prev_line", fr_prev_line, 28'h4A);
    chk("R7 no decode in restart cycle", ins_valid, 0);
    // R9: stale generation popped, not decoded
    #1 chk("R9 stale pop", bnd_pop, 1);
    step();
    chk("R9 stale not decoded", ins_valid, 0);
    chk("R1 fr pulse one cycle", fr_valid, 0);
    bnd_gen = gup;
    step();
    chk("R4 op after restart", ins_op, 5);
    chk("R4 gen after restart", ins_gen, 8'h55);
    chk("R4 lin pc", ins_lin_pc, 32'h201);

    // R8/R9: wrong line, successor also wrong
    bnd_line = 28'h21; bnd_next_line = 28'h22;
    #1 chk("R9 line mismatch pop", bnd_pop, 1);
    step();
    chk("R8 fr_valid", fr_valid, 1);
    chk("R8 fr_gen", fr_gen, gup + 8'd1);
    chk("R8 fr_new_line", fr_new_line, 28'h20);
    chk("R8 fr_prev_line", fr_prev_line, 28'h21);
    gup = gup + 8'd1;
    bnd_gen = gup; bnd_line = 28'h1F; bnd_next_line = 28'h20;
    #1 chk("R9 pop when successor matches", bnd_pop, 1);
    step();
    chk("R8 no restart when successor matches", fr_valid, 0);
    bnd_valid = 1'b0;

    // vector table (R2, R4)
    for (int k = 0; k < 4; k++) begin
      logic [31:0] base;
      base = 32'h100 + k * 16;
      do_rs(base, 8'h20 + 8'(k), 28'h0);
      bnd_data = '0; bnd_data[31:0] = VEC[k];
      offer(base[31:4]);
      model(VEC[k]);
      step();
      bnd_valid = 1'b0;
      chk("R4 vec valid", ins_valid, 1);
      chk("R4 vec size", ins_size, msz);
      chk("R2 vec opcode", ins_op, mf[0]);
      chk("R2 vec flags", ins_flags, mf[1]);
      chk("R2 vec src1", ins_src1, mf[2]);
      chk("R2 vec src2", ins_src2, mf[3]);
      chk("R4 vec gen", ins_gen, 8'h20 + 8'(k));
      chk("R4 vec lin pc", ins_lin_pc, base + msz);
      chk("R5 vec pred pc", ins_pred_pc, base + msz);
      chk("R5 vec pred ok", ins_pred_ok, 1);
    end

    // R3: five-byte instruction over two cycles, then one per cycle
    do_rs(32'h50, 8'h33, 28'h0);
    bnd_data = '0;
    put(0, 8'h81); put(1, 8'h81); put(2, 8'h81); put(3, 8'h81); put(4, 8'h02);
    put(5, 8'h03); put(6, 8'h04); put(7, 8'h06);
    offer(28'h5);
    step();
    chk("R3 four bytes no emit", ins_valid, 0);
    step();
    chk("R3 long size", ins_size, 5);
    chk("R3 long op", ins_op, 32'h11112);
    chk("R3 long lin pc", ins_lin_pc, 32'h55);
    #1 chk("R9 same line no pop", bnd_pop, 0);
    step();
    chk("R3 one per cycle a", ins_op, 3);
    chk("R3 one per cycle a pc", ins_lin_pc, 32'h56);
    step();
    chk("R3 one per cycle b", ins_op, 4);
    chk("R3 one per cycle b pc", ins_lin_pc, 32'h57);
    // R10 backpressure
    ins_ready = 1'b0;
    step();
    chk("R10 held valid", ins_valid, 1);
    chk("R10 held op", ins_op, 4);
    ins_ready = 1'b1;
    step();
    chk("R10 resume op", ins_op, 6);
    chk("R10 resume pc", ins_lin_pc, 32'h58);
    bnd_valid = 1'b0;

    // R5 known target, known taken
    run_jump(32'h400, 8'h01, 4'h3, 4'h3, 4'h0, 4'h0);
    chk("R9 pop after redirect", pop_s, 1);
    chk("R5 taken pred pc", ins_pred_pc, 32'h30);
    chk("R5 taken lin pc", ins_lin_pc, 32'h405);
    chk("R5 taken ok", ins_pred_ok, 1);
    chk("R8 redirect fr_valid", fr_valid, 1);
    chk("R8 redirect fr_new_line", fr_new_line, 28'h3);
    chk("R8 redirect fr_prev_line", fr_prev_line, 28'h40);
    chk("R8 redirect fr_gen", fr_gen, gup + 8'd1);
    gup = gup + 8'd1;
    // R5 known target, known not taken
    run_jump(32'h410, 8'h02, 4'h3, 4'h3, 4'h0, 4'h0);
    chk("R5 not taken pred pc", ins_pred_pc, 32'h415);
    chk("R8 not taken no restart", fr_valid, 0);
    chk("R9 not taken no pop", pop_s, 0);
    // R5 known target below pc, unknown condition
    run_jump(32'h420, 8'h01, 4'h1, 4'h3, 4'h0, 4'h5);
    chk("R5 backward pred pc", ins_pred_pc, 32'h30);
    chk("R5 backward ok", ins_pred_ok, 1);
    gup = gup + 8'd1;
    // R5 known target above pc, unknown condition
    run_jump(32'h030, 8'h01, 4'h1, 4'hF, 4'h0, 4'h5);
    chk("R5 forward pred pc", ins_pred_pc, 32'h35);
    chk("R5 forward ok", ins_pred_ok, 1);
    // R5 unknown target, known not taken
    run_jump(32'h450, 8'h02, 4'h2, 4'h0, 4'h0, 4'h0);
    chk("R5 unknown target not taken ok", ins_pred_ok, 1);
    chk("R5 unknown target not taken pc", ins_pred_pc, 32'h455);
    // R6 unknown target, known taken
    run_jump(32'h440, 8'h01, 4'h2, 4'h0, 4'h0, 4'h0);
    chk("R6 unpredictable ok", ins_pred_ok, 0);
    chk("R6 unpredictable valid", ins_valid, 1);
    put(5, 8'h07);
    #1 chk("R6 stall no pop", bnd_pop, 0);
    step();
    chk("R6 stall no emit", ins_valid, 0);
    step();
    chk("R6 stall still no emit", ins_valid, 0);
    // R7 restart clears the stall
    do_rs(32'h460, 8'h44, 28'h44);
    bnd_data = '0; put(0, 8'h09);
    offer(28'h46);
    step();
    chk("R7 resume after stall", ins_valid, 1);
    chk("R7 resume op", ins_op, 9);
    chk("R7 resume gen", ins_gen, 8'h44);
    bnd_valid = 1'b0;
    step();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule